// File: doc/BRIEF.md
# Memory Ordering Queue Tracker

This block tracks the memory operations that are in flight inside a load-store unit. Every load and every store takes an entry when it is dispatched. The entry records the operation's type and the entries that were dispatched before it. An entry goes away on the event that belongs to its type. A load entry is freed when the load has completed and returned its data. A store entry is freed as soon as the store's address is translated. Entries therefore leave in any order, and a new operation takes the lowest-numbered free slot.

Issue logic sends a slot number to the query port. For that slot it gets back two flags. One says whether an older store is still waiting for its address. The other says whether an older load is still pending. Older loads never hold a load back. Older stores hold it back only while their address is unknown; conflict checks against translated stores are done outside the block. Each slot has an ordering vector that marks which live entries are older. Program order is therefore kept no matter which slots are reused. A three-state occupancy controller drives the full flag, which stalls dispatch, and the empty flag.

The controller has three states, named as follows:
- `OCC_EMPTY`: no entries are live.
- `OCC_PARTIAL`: between one and DEPTH-1 entries are live.
- `OCC_FULL`: all DEPTH entries are live.

Its transitions, named as follows:
- `fill`: from EMPTY to PARTIAL, or to FULL when DEPTH is 1, on an accepted dispatch.
- `top_off`: from PARTIAL to FULL when the live count reaches DEPTH.
- `drain`: from PARTIAL to EMPTY when the last entry leaves.
- `unstall`: from FULL to PARTIAL on any release.

Top module: `mem_order_tracker`

## Requirements
- R1: After synchronous active-high reset, `empty`=1, `full`=0 and `qry_valid`=0 for every slot.
- R2: When `disp_valid`=1 and `full`=0, the dispatch is accepted. `disp_slot` shows the lowest-numbered free slot in the same cycle. From the next cycle that slot reads `qry_valid`=1, and `qry_is_store` equals `disp_is_store` (1 means store, 0 means load).
- R3: `full` rises once all 16 slots are live. A dispatch presented while `full`=1 is ignored, even when a release is accepted in the same cycle. The release still takes effect.
- R4: When `ld_rel_valid`=1 and `ld_rel_slot` names a live load, that slot reads `qry_valid`=0 from the next cycle.
- R5: When `st_rel_valid`=1 and `st_rel_slot` names a live store, that slot reads `qry_valid`=0 from the next cycle.
- R6: A release that names a free slot, or a live entry of the other type, has no effect.
- R7: One dispatch, one load release and one store release in the same cycle all take effect. A slot freed in that cycle is not reused in that cycle.
- R8: `qry_older_store`=1 exactly when the queried slot is live and some live store was dispatched before it.
- R9: Older live loads never set `qry_older_store`. They are reported on `qry_older_load` instead.
- R10: Age is set by dispatch order, not by slot index. A reused low slot is younger than every entry that was live when it was dispatched.
- R11: `empty` is 1 exactly when no slot is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_is_store | input | 1 | Type of the dispatched operation: 1 store, 0 load |
| disp_slot | output | 4 | Slot that an accepted dispatch takes |
| ld_rel_valid | input | 1 | Load completed and returned its data |
| ld_rel_slot | input | 4 | Slot of the completed load |
| st_rel_valid | input | 1 | Store address translated |
| st_rel_slot | input | 4 | Slot of the translated store |
| qry_slot | input | 4 | Slot being queried |
| qry_valid | output | 1 | The queried slot is live |
| qry_is_store | output | 1 | The queried slot holds a store |
| qry_older_store | output | 1 | An older store with an untranslated address exists |
| qry_older_load | output | 1 | An older pending load exists |
| full | output | 1 | All slots are live; dispatch must stall |
| empty | output | 1 | No slot is live |

## Verification
Dispatch and both kinds of release can fall in the same cycle. The bench provokes this two ways. In one cycle it presents a dispatch, a load release and a store release together. It also releases an entry while the queue is full and a dispatch is waiting. A reference model of slots and dispatch sequence numbers judges each case. Every cycle the bench sweeps all query slots and compares them with the model, and a scoreboard compares every accepted dispatch slot with the slot the model expects.

// File: rtl/mot_pkg.sv
package mot_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/mot_slot_pick.sv
module mot_slot_pick #(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] busy,
    output logic [IW-1:0]    slot,
    output logic             found
);
    // lowest free index wins: scan downward so the last hit is the lowest
    always_comb begin
        slot  = '0;
        found = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                slot  = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mot_age_matrix.sv
module mot_age_matrix #(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic [IW-1:0]    alloc_slot,
    input  logic             alloc_store,
    input  logic [DEPTH-1:0] rel_mask,
    input  logic [IW-1:0]    qry_slot,
    output logic [DEPTH-1:0] live_q,
    output logic [DEPTH-1:0] kind_q,
    output logic             qry_live,
    output logic             qry_store,
    output logic             qry_old_st,
    output logic             qry_old_ld
);
    // older_q[i][j] = 1 when slot j was live at the time slot i was dispatched
    logic [DEPTH-1:0] older_q [DEPTH];
    logic [DEPTH-1:0] older_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            kind_q <= '0;
            for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_en && alloc_slot == IW'(i)) begin
                    live_q[i]  <= 1'b1;
                    kind_q[i]  <= alloc_store;
                    older_q[i] <= live_q & ~rel_mask;
                end else begin
                    if (rel_mask[i]) live_q[i] <= 1'b0;
                    // a reused slot must not look older to anyone
                    if (alloc_en) older_q[i][alloc_slot] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        older_vec  = older_q[qry_slot] & live_q;
        qry_live   = live_q[qry_slot];
        qry_store  = kind_q[qry_slot];
        qry_old_st = qry_live & (|(older_vec & kind_q));
        qry_old_ld = qry_live & (|(older_vec & ~kind_q));
    end

    // R10
    no_self_older_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_en |=> !older_q[$past(alloc_slot)][$past(alloc_slot)]);
endmodule

// File: rtl/mot_occ_fsm.sv
module mot_occ_fsm
    import mot_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       inc,
    input  logic [1:0] dec,
    output logic       full,
    output logic       empty
);
    occ_state_e    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;

    assign cnt_n = cnt_q + CW'(inc) - CW'(dec);

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            OCC_EMPTY:   if (inc) st_n = (cnt_n == CW'(DEPTH)) ? OCC_FULL : OCC_PARTIAL;
            OCC_PARTIAL: begin
                if (cnt_n == CW'(DEPTH))  st_n = OCC_FULL;
                else if (cnt_n == '0)     st_n = OCC_EMPTY;
            end
            OCC_FULL:    if (dec != 2'd0) st_n = (cnt_n == '0) ? OCC_EMPTY : OCC_PARTIAL;
            default:     st_n = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= OCC_EMPTY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        full  = (st_q == OCC_FULL);
        empty = (st_q == OCC_EMPTY);
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !inc);
    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> dec == 2'd0);
endmodule

// File: rtl/mem_order_tracker.sv
module mem_order_tracker #(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          disp_valid,
    input  logic          disp_is_store,
    output logic [IW-1:0] disp_slot,
    input  logic          ld_rel_valid,
    input  logic [IW-1:0] ld_rel_slot,
    input  logic          st_rel_valid,
    input  logic [IW-1:0] st_rel_slot,
    input  logic [IW-1:0] qry_slot,
    output logic          qry_valid,
    output logic          qry_is_store,
    output logic          qry_older_store,
    output logic          qry_older_load,
    output logic          full,
    output logic          empty
);
    logic [DEPTH-1:0] live_q, kind_q, rel_mask;
    logic             free_found, alloc_ok, ld_ok, st_ok;
    logic [1:0]       dec;

    mot_slot_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
        .busy(live_q), .slot(disp_slot), .found(free_found)
    );

    always_comb begin
        alloc_ok = disp_valid & ~full & free_found;
        ld_ok    = ld_rel_valid & live_q[ld_rel_slot] & ~kind_q[ld_rel_slot];
        st_ok    = st_rel_valid & live_q[st_rel_slot] &  kind_q[st_rel_slot];
        rel_mask = '0;
        if (ld_ok) rel_mask[ld_rel_slot] = 1'b1;
        if (st_ok) rel_mask[st_rel_slot] = 1'b1;
        dec = {1'b0, ld_ok} + {1'b0, st_ok};
    end

    mot_age_matrix #(.DEPTH(DEPTH), .IW(IW)) u_age (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_ok), .alloc_slot(disp_slot), .alloc_store(disp_is_store),
        .rel_mask(rel_mask), .qry_slot(qry_slot),
        .live_q(live_q), .kind_q(kind_q),
        .qry_live(qry_valid), .qry_store(qry_is_store),
        .qry_old_st(qry_older_store), .qry_old_ld(qry_older_load)
    );

    mot_occ_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst(rst), .inc(alloc_ok), .dec(dec),
        .full(full), .empty(empty)
    );

    // R2
    alloc_slot_free_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !full) |-> !live_q[disp_slot]);
    // R2
    alloc_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !full) |=> (live_q[$past(disp_slot)] &&
                                   kind_q[$past(disp_slot)] == $past(disp_is_store)));
    // R3
    full_all_live_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> (&live_q));
    // R11
    empty_none_live_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (live_q == '0));
    // R4
    ld_free_chk: assert property (@(posedge clk) disable iff (rst)
        ld_ok |=> !live_q[$past(ld_rel_slot)]);
    // R5
    st_free_chk: assert property (@(posedge clk) disable iff (rst)
        st_ok |=> !live_q[$past(st_rel_slot)]);
endmodule

// File: tb/sim_mem_order_tracker.sv
`timescale 1ns/1ps
module sim_mem_order_tracker;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       disp_valid = 1'b0, disp_is_store = 1'b0;
    logic [3:0] disp_slot;
    logic       ld_rel_valid = 1'b0, st_rel_valid = 1'b0;
    logic [3:0] ld_rel_slot = '0, st_rel_slot = '0, qry_slot = '0;
    logic       qry_valid, qry_is_store, qry_older_store, qry_older_load;
    logic       full, empty;

    int checks = 0;
    int failures = 0;

    bit mvalid [N];
    bit mstore [N];
    int mseq   [N];
    int seqctr = 0;
    int exp_q [$];

    always #2.5 clk = ~clk;

    mem_order_tracker u0 (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_is_store(disp_is_store), .disp_slot(disp_slot),
        .ld_rel_valid(ld_rel_valid), .ld_rel_slot(ld_rel_slot),
        .st_rel_valid(st_rel_valid), .st_rel_slot(st_rel_slot),
        .qry_slot(qry_slot), .qry_valid(qry_valid), .qry_is_store(qry_is_store),
        .qry_older_store(qry_older_store), .qry_older_load(qry_older_load),
        .full(full), .empty(empty)
    );

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic int mcount();
        int c = 0;
        for (int j = 0; j < N; j++) c += int'(mvalid[j]);
        return c;
    endfunction

    function automatic int lowest_free();
        for (int j = 0; j < N; j++) if (!mvalid[j]) return j;
        return 0;
    endfunction

    function automatic bit m_older(int s, bit want_store);
        if (!mvalid[s]) return 1'b0;
        for (int j = 0; j < N; j++)
            if (mvalid[j] && mstore[j] == want_store && mseq[j] < mseq[s]) return 1'b1;
        return 1'b0;
    endfunction

    // scoreboard monitor: every accepted dispatch must land on the expected slot
    always @(negedge clk) begin
        if (!rst && disp_valid && !full) begin
            if (exp_q.size() == 0) chk("R3", "unexpected accept", 1, 0);
            else chk("R2", "disp_slot", int'(disp_slot), exp_q.pop_front());
        end
    end

    task automatic sweep_queries();
        for (int s = 0; s < N; s++) begin
            qry_slot = 4'(s);
            #0.1;
            chk("R2", $sformatf("qry_valid[%0d]", s), int'(qry_valid), int'(mvalid[s]));
            if (mvalid[s]) chk("R2", $sformatf("qry_is_store[%0d]", s), int'(qry_is_store), int'(mstore[s]));
            chk("R8", $sformatf("older_store[%0d]", s), int'(qry_older_store), int'(m_older(s, 1'b1)));
            chk("R9", $sformatf("older_load[%0d]", s), int'(qry_older_load), int'(m_older(s, 1'b0)));
        end
    endtask

    // called just after a rising edge; returns just after the next rising edge
    task automatic cycle(bit dv, bit ds, bit lv, int ls, bit sv, int ss);
        bit ld_m, st_m;
        int a;
        disp_valid = dv; disp_is_store = ds;
        ld_rel_valid = lv; ld_rel_slot = 4'(ls);
        st_rel_valid = sv; st_rel_slot = 4'(ss);
        if (dv && mcount() < N) exp_q.push_back(lowest_free());
        @(negedge clk);
        chk("R3", "full", int'(full), int'(mcount() == N));
        chk("R11", "empty", int'(empty), int'(mcount() == 0));
        sweep_queries();
        @(posedge clk);
        ld_m = lv && mvalid[ls] && !mstore[ls];
        st_m = sv && mvalid[ss] && mstore[ss];
        if (dv && mcount() < N) begin
            a = lowest_free();
            mvalid[a] = 1'b1; mstore[a] = ds; mseq[a] = seqctr; seqctr++;
        end
        if (ld_m) mvalid[ls] = 1'b0;
        if (st_m) mvalid[ss] = 1'b0;
        #1;
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 0, 0);
    endtask

    task automatic probe(string req, int s, int v, int ost, int old);
        qry_slot = 4'(s);
        #0.1;
        chk(req, $sformatf("valid[%0d]", s), int'(qry_valid), v);
        chk(req, $sformatf("older_store[%0d]", s), int'(qry_older_store), ost);
        chk(req, $sformatf("older_load[%0d]", s), int'(qry_older_load), old);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int j = 0; j < N; j++) begin mvalid[j] = 0; mstore[j] = 0; mseq[j] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        for (int s = 0; s < N; s++) begin
            qry_slot = 4'(s); #0.1;
            chk("R1", $sformatf("qry_valid[%0d]", s), int'(qry_valid), 0);
        end
        idle();
        // load s0, store s1, load s2, load s3
        cycle(1, 0, 0, 0, 0, 0);
        cycle(1, 1, 0, 0, 0, 0);
        cycle(1, 0, 0, 0, 0, 0);
        cycle(1, 0, 0, 0, 0, 0);
        probe("R8", 2, 1, 1, 1);
        probe("R8", 0, 1, 0, 0);
        probe("R9", 1, 1, 0, 1);
        // R5 store release at translation
        cycle(0, 0, 0, 0, 1, 1);
        probe("R5", 1, 0, 0, 0);
        probe("R9", 3, 1, 0, 1);
        // R6 load release on free slot, store release on a load
        cycle(0, 0, 1, 1, 1, 0);
        probe("R6", 0, 1, 0, 0);
        // R4 load release after data return
        cycle(0, 0, 1, 0, 0, 0);
        probe("R4", 0, 0, 0, 0);
        // R10 store reuses slot 0 but is youngest
        cycle(1, 1, 0, 0, 0, 0);
        probe("R10", 0, 1, 0, 1);
        probe("R10", 2, 1, 0, 0);
        // R7 dispatch + load release + store release together
        cycle(1, 0, 1, 2, 1, 0);
        probe("R7", 0, 0, 0, 0);
        probe("R7", 2, 0, 0, 0);
        probe("R7", 1, 1, 0, 1);
        // R3 fill to full
        while (mcount() < N) cycle(1, 1, 0, 0, 0, 0);
        chk("R3", "full after fill", int'(full), 1);
        cycle(1, 0, 0, 0, 0, 0);
        chk("R3", "full holds", int'(full), 1);
        // release while full with dispatch waiting: dispatch dropped
        cycle(1, 0, 0, 0, 1, 5);
        chk("R3", "full drops after release", int'(full), 0);
        probe("R3", 5, 0, 0, 0);
        idle();
        // random traffic
        for (int k = 0; k < 400; k++)
            cycle($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, $urandom_range(0, N - 1),
                  $urandom_range(0, 1) == 1, $urandom_range(0, N - 1));
        // drain
        for (int s = 0; s < N; s++)
            if (mvalid[s]) cycle(0, 0, !mstore[s], s, mstore[s], s);
        idle();
        chk("R11", "empty after drain", int'(empty), 1);
        chk("R2", "scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule